// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

One DMA channel that moves data words between a device-side stream and a word-addressed memory port. Each buffer is a pair of addresses: the first word and an exclusive end, which is the first word plus the length. The live buffer sits in a *current* pair (next pointer and limit). A second buffer can wait in a *queued* pair (start and stop) while the live one is in flight. When the live buffer runs out and software has marked the queued pair valid, the hardware copies the queued pair into the current pair in the same clock edge and keeps running. Software can then refill the queued pair while the new buffer is moving.

Software reaches the channel through a 32-bit register port. The port holds a control/status word, the four live address registers and four saved copies. The channel writes the saved limit with the address where a buffer actually ended, so software can work out the real transfer length. A device may close a receive packet early. Bit 31 of a limit value is an end-of-packet marker: it takes no part in address comparison and is passed to the device with the final word of the buffer. A memory error response stops the channel and records the faulting address. Each finished buffer sets a completion flag, which drives an interrupt output when interrupts are enabled.

Top module: `chain_dma_chan`

## Requirements
- R1: After a low level on `rst_n`, the status word reads 0, every address register reads 0, and `irq`, `mem_req` and `dev_in_ready` are low.
- R2: A control write with bit 3 (reset) set clears enable, update-pending, complete and bus-exception, and latches the direction from bit 5 (1 = device to memory, 0 = memory to device). Address registers keep their values unless bit 4 (init) is also set, in which case all eight become 0.
- R3: Word offsets 1..8 (current next, current limit, queued start, queued stop, saved next, saved limit, saved start, saved stop) are written and read back as full 32-bit values. Offset 0 reads the status: bit 0 enable, bit 1 update-pending, bit 2 complete, bit 3 bus exception, bit 5 direction, bit 6 interrupt enable.
- R4: In memory-to-device direction the channel reads addresses next..limit-1 in ascending order. Each word appears on `dev_out_data` with a one-cycle `dev_out_valid` pulse, one cycle after the memory acknowledges it.
- R5: In device-to-memory direction, each word accepted from the device is written to the next successive address.
- R6: A finished buffer sets complete. `irq` is complete ANDed with the interrupt enable (control bit 6 sets it, bit 7 clears it). Complete stays set until a control write with bit 2 (clear-complete) or bit 3.
- R7: If update-pending (set by control bit 1) is set when a buffer finishes, start/stop are copied into next/limit, update-pending clears and enable stays set. Enable is set by control bit 0.
- R8: If update-pending is clear when a buffer finishes, enable clears and no further memory request is made.
- R9: At the end of a buffer, saved limit receives the end address reached, with bit 31 copied from the limit. A device-to-memory word flagged `dev_in_last` ends the buffer after that word is stored.
- R10: Bit 31 of the limit is ignored when comparing addresses. When it is set, `dev_out_last` accompanies the final word of that buffer.
- R11: A memory error response sets bus exception and complete, clears enable, and stores the faulting address in saved next.
- R12: A buffer whose next equals its limit finishes without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory error response |
| dev_in_valid | input | 1 | Device word available |
| dev_in_data | input | DATA_W | Device word |
| dev_in_last | input | 1 | Device word ends the packet |
| dev_in_ready | output | 1 | Channel accepts a device word |
| dev_out_valid | output | 1 | Word to device valid |
| dev_out_data | output | DATA_W | Word to device |
| dev_out_last | output | 1 | Final word of a marked buffer |

## Verification
A register write is visible on the read port in the cycle after its strobe. A memory word reaches the device one cycle after its acknowledge. Complete, promotion and saved limit all change on the same edge that accepts the final acknowledge, and `irq` follows complete with no further delay. The bench drives inputs on the falling edge and reads results at the next falling edge. It collects device-side words in a falling-edge monitor and waits for status changes by polling, with a bounded count, so a late or early result shows up as a wrong value or an expired poll rather than as a race.

// File: rtl/chain_dma_pkg.sv
// Shared constants and types for the chained DMA channel.
// Assumes a 32-bit register port addressed by 4-bit word offsets.
package chain_dma_pkg;
    localparam int ADDR_W   = 32;
    localparam int REG_AW   = 4;
    localparam int NUM_AREG = 8;

    // address register slots; register offset = slot + 1
    localparam int IX_NEXT  = 0;
    localparam int IX_LIMIT = 1;
    localparam int IX_START = 2;
    localparam int IX_STOP  = 3;
    localparam int IX_SVNXT = 4;
    localparam int IX_SVLIM = 5;

    // control write bits
    localparam int CMD_SET_EN  = 0;
    localparam int CMD_SET_UPD = 1;
    localparam int CMD_CLR_DN  = 2;
    localparam int CMD_RESET   = 3;
    localparam int CMD_INIT    = 4;
    localparam int CMD_DIR     = 5;
    localparam int CMD_SET_IE  = 6;
    localparam int CMD_CLR_IE  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MEM   = 2'd2
    } eng_state_e;
endpackage

// File: rtl/chain_dma_regs.sv
// Register file and channel flags.
// Holds the eight address registers and the enable/update/complete/bus-exception flags.
// Applies engine events (advance, buffer end, error) and software writes.
// Assumes that software writes to an address register override a hardware update in the same cycle.
module chain_dma_regs
    import chain_dma_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      wr_addr,
    input  logic [ADDR_W-1:0]      wr_data,
    input  logic [REG_AW-1:0]      rd_addr,
    output logic [ADDR_W-1:0]      rd_data,
    input  logic                   ev_adv,
    input  logic                   ev_end,
    input  logic [ADDR_W-2:0]      ev_end_addr,
    input  logic                   ev_err,
    input  logic [ADDR_W-2:0]      ev_err_addr,
    output logic [ADDR_W-2:0]      cur_next,
    output logic [ADDR_W-2:0]      cur_limit,
    output logic                   limit_eop,
    output logic                   run_en,
    output logic                   dir_wr,
    output logic                   abort,
    output logic                   irq
);
    logic [ADDR_W-1:0] areg [NUM_AREG];
    logic upd_q, done_q, bexc_q, ie_q;
    logic csr_wr, sw_reset, clr_hit;

    assign csr_wr   = wr_en && (wr_addr == '0);
    assign sw_reset = csr_wr && wr_data[CMD_RESET];
    assign clr_hit  = csr_wr && (wr_data[CMD_CLR_DN] || wr_data[CMD_RESET]);
    assign abort    = sw_reset;

    // Flag and address register updates: hardware events first, software last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AREG; i++) areg[i] <= '0;
            run_en <= 1'b0;
            upd_q  <= 1'b0;
            done_q <= 1'b0;
            bexc_q <= 1'b0;
            ie_q   <= 1'b0;
            dir_wr <= 1'b0;
        end else begin
            if (!sw_reset) begin
                if (ev_adv)
                    areg[IX_NEXT] <= {areg[IX_NEXT][ADDR_W-1], areg[IX_NEXT][ADDR_W-2:0] + 1'b1};
                if (ev_end) begin
                    done_q <= 1'b1;
                    areg[IX_SVLIM] <= {areg[IX_LIMIT][ADDR_W-1], ev_end_addr};
                    if (upd_q) begin
                        areg[IX_NEXT]  <= areg[IX_START];
                        areg[IX_LIMIT] <= areg[IX_STOP];
                        upd_q <= 1'b0;
                    end else begin
                        run_en <= 1'b0;
                    end
                end
                if (ev_err) begin
                    bexc_q <= 1'b1;
                    done_q <= 1'b1;
                    run_en <= 1'b0;
                    areg[IX_SVNXT] <= {1'b0, ev_err_addr};
                end
            end
            for (int i = 0; i < NUM_AREG; i++) begin
                if (wr_en && wr_addr == REG_AW'(i + 1)) areg[i] <= wr_data;
            end
            if (csr_wr) begin
                if (wr_data[CMD_RESET]) begin
                    run_en <= 1'b0;
                    upd_q  <= 1'b0;
                    done_q <= 1'b0;
                    bexc_q <= 1'b0;
                    dir_wr <= wr_data[CMD_DIR];
                    if (wr_data[CMD_INIT])
                        for (int i = 0; i < NUM_AREG; i++) areg[i] <= '0;
                end
                if (wr_data[CMD_CLR_DN])  done_q <= 1'b0;
                if (wr_data[CMD_SET_EN])  run_en <= 1'b1;
                if (wr_data[CMD_SET_UPD]) upd_q  <= 1'b1;
                if (wr_data[CMD_SET_IE])  ie_q   <= 1'b1;
                if (wr_data[CMD_CLR_IE])  ie_q   <= 1'b0;
            end
        end
    end

    // Read mux: status word at offset 0, address registers above it.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[0] = run_en;
            rd_data[1] = upd_q;
            rd_data[2] = done_q;
            rd_data[3] = bexc_q;
            rd_data[5] = dir_wr;
            rd_data[6] = ie_q;
        end
        for (int i = 0; i < NUM_AREG; i++) begin
            if (rd_addr == REG_AW'(i + 1)) rd_data = areg[i];
        end
    end

    assign cur_next  = areg[IX_NEXT][ADDR_W-2:0];
    assign cur_limit = areg[IX_LIMIT][ADDR_W-2:0];
    assign limit_eop = areg[IX_LIMIT][ADDR_W-1];
    assign irq       = done_q && ie_q;

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !clr_hit |=> done_q);
    assert_chain_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end && upd_q && run_en && !csr_wr |=> run_en && !upd_q);
    assert_stop_no_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end && !upd_q && !csr_wr |=> !run_en);
    assert_err_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err && !csr_wr |=> bexc_q && done_q && !run_en);
    assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset && !wr_data[CMD_SET_EN] && !wr_data[CMD_SET_UPD] |=> !run_en && !upd_q && !done_q && !bexc_q);
endmodule

// File: rtl/chain_dma_engine.sv
// Transfer engine: walks the current buffer one word at a time.
// In memory-to-device direction it reads memory and forwards each word.
// In device-to-memory direction it takes a device word, then writes it.
// Reports advance, buffer-end and error events to the register file.
// Assumes one outstanding memory request, terminated by ack or err.
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               dir_wr,
    input  logic               abort,
    input  logic [ADDR_W-2:0]  cur_next,
    input  logic [ADDR_W-2:0]  cur_limit,
    input  logic               limit_eop,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic               dev_in_valid,
    input  logic [DATA_W-1:0]  dev_in_data,
    input  logic               dev_in_last,
    output logic               dev_in_ready,
    output logic               dev_out_valid,
    output logic [DATA_W-1:0]  dev_out_data,
    output logic               dev_out_last,
    output logic               ev_adv,
    output logic               ev_end,
    output logic [ADDR_W-2:0]  ev_end_addr,
    output logic               ev_err,
    output logic [ADDR_W-2:0]  ev_err_addr
);
    eng_state_e        state_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_last_q;
    logic [ADDR_W-2:0] next_inc;
    logic              cur_empty, hit_limit, mem_done;

    assign next_inc  = cur_next + 1'b1;
    assign cur_empty = (cur_next == cur_limit);
    assign hit_limit = (next_inc == cur_limit);
    assign mem_done  = (state_q == ST_MEM) && mem_ack && !mem_err && !abort;

    assign mem_req      = (state_q == ST_MEM);
    assign mem_we       = dir_wr;
    assign mem_addr     = {1'b0, cur_next};
    assign mem_wdata    = hold_q;
    assign dev_in_ready = (state_q == ST_FETCH) && run_en && !abort;
    assign ev_err_addr  = cur_next;

    // Event decode for the register file.
    always_comb begin
        ev_adv      = 1'b0;
        ev_end      = 1'b0;
        ev_err      = 1'b0;
        ev_end_addr = cur_next;
        if (state_q == ST_IDLE) begin
            if (run_en && !abort && cur_empty) ev_end = 1'b1;
        end else if (state_q == ST_MEM && !abort) begin
            if (mem_err) begin
                ev_err = 1'b1;
            end else if (mem_ack) begin
                ev_adv = 1'b1;
                if (hit_limit || (dir_wr && hold_last_q)) begin
                    ev_end      = 1'b1;
                    ev_end_addr = next_inc;
                end
            end
        end
    end

    // Sequencer: idle -> (fetch) -> memory access -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_q      <= '0;
            hold_last_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run_en && !abort && !cur_empty)
                        state_q <= dir_wr ? ST_FETCH : ST_MEM;
                end
                ST_FETCH: begin
                    if (abort || !run_en) begin
                        state_q <= ST_IDLE;
                    end else if (dev_in_valid) begin
                        hold_q      <= dev_in_data;
                        hold_last_q <= dev_in_last;
                        state_q     <= ST_MEM;
                    end
                end
                ST_MEM: begin
                    if (abort || mem_ack || mem_err) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Device output register: one pulse per word read from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_out_valid <= 1'b0;
            dev_out_data  <= '0;
            dev_out_last  <= 1'b0;
        end else begin
            dev_out_valid <= mem_done && !dir_wr;
            dev_out_last  <= mem_done && !dir_wr && hit_limit && limit_eop;
            if (mem_done && !dir_wr) dev_out_data <= mem_rdata;
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mem_err && !abort |=> mem_req && $stable(mem_addr));
    assert_no_req_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && cur_empty |=> !mem_req);
    assert_out_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> $past(mem_ack) && !$past(dir_wr));
endmodule

// File: rtl/chain_dma_chan.sv
// Top of the chained double-buffered DMA channel.
// Connects the register file to the transfer engine.
// Assumes a word-addressed memory, with address bit 31 reserved as the end-of-packet marker.
module chain_dma_chan
    import chain_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [3:0]         reg_waddr,
    input  logic [31:0]        reg_wdata,
    input  logic [3:0]         reg_raddr,
    output logic [31:0]        reg_rdata,
    output logic               irq,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic               dev_in_valid,
    input  logic [DATA_W-1:0]  dev_in_data,
    input  logic               dev_in_last,
    output logic               dev_in_ready,
    output logic               dev_out_valid,
    output logic [DATA_W-1:0]  dev_out_data,
    output logic               dev_out_last
);
    logic [ADDR_W-2:0] cur_next, cur_limit, ev_end_addr, ev_err_addr;
    logic limit_eop, run_en, dir_wr, abort, ev_adv, ev_end, ev_err;

    chain_dma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .ev_adv(ev_adv), .ev_end(ev_end), .ev_end_addr(ev_end_addr),
        .ev_err(ev_err), .ev_err_addr(ev_err_addr),
        .cur_next(cur_next), .cur_limit(cur_limit), .limit_eop(limit_eop),
        .run_en(run_en), .dir_wr(dir_wr), .abort(abort), .irq(irq)
    );

    chain_dma_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .dir_wr(dir_wr), .abort(abort),
        .cur_next(cur_next), .cur_limit(cur_limit), .limit_eop(limit_eop),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_last(dev_in_last), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_last(dev_out_last),
        .ev_adv(ev_adv), .ev_end(ev_end), .ev_end_addr(ev_end_addr),
        .ev_err(ev_err), .ev_err_addr(ev_err_addr)
    );
endmodule

// File: tb/chain_dma_chan_tb_top.sv
module chain_dma_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic        dev_in_valid = 1'b0;
    logic [31:0] dev_in_data = '0;
    logic        dev_in_last = 1'b0;
    logic        dev_in_ready, dev_out_valid, dev_out_last;
    logic [31:0] dev_out_data;

    int checks = 0, failures = 0;
    bit done_flag = 0;

    logic [31:0] bmem [256];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int req_cnt = 0;
    logic [31:0] rx_data [16];
    logic        rx_last [16];
    int rx_n = 0;
    bit src_on = 0;
    int src_idx = 0, src_last_idx = 0;
    bit took = 0;

    localparam logic [3:0] O_CSR = 4'd0, O_NEXT = 4'd1, O_LIM = 4'd2, O_START = 4'd3,
                           O_STOP = 4'd4, O_SVNXT = 4'd5, O_SVLIM = 4'd6, O_SVST = 4'd7,
                           O_SVSP = 4'd8;
    localparam logic [31:0] C_EN = 32'h1, C_UPD = 32'h2, C_CLR = 32'h4, C_RST = 32'h8,
                            C_INIT = 32'h10, C_DIRW = 32'h20, C_SIE = 32'h40;

    // register write vectors: {offset, value}; read back must equal value
    localparam logic [35:0] VEC [8] = '{
        {4'd1, 32'h0000_1234}, {4'd2, 32'h8000_0123}, {4'd3, 32'h0BAD_F00D},
        {4'd4, 32'h7FFF_FFFF}, {4'd5, 32'hDEAD_BEEF}, {4'd6, 32'h1357_9BDF},
        {4'd7, 32'hCAFE_0001}, {4'd8, 32'h8000_0000}};

    chain_dma_chan #(.DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_last(dev_in_last), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_last(dev_out_last));

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_pat(logic [31:0] a);
        return 32'hA5A5_0000 ^ a;
    endfunction

    // memory model: answers a request at the falling edge, one pulse per access
    always @(negedge clk) begin
        if (mem_req) req_cnt++;
        if (mem_ack || mem_err) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            if (mem_addr == err_addr) begin
                mem_err = 1'b1;
            end else begin
                mem_ack = 1'b1;
                mem_rdata = mem_pat(mem_addr);
                if (mem_we) bmem[mem_addr[7:0]] = mem_wdata;
            end
        end
    end

    // device side: output monitor and input source
    always @(negedge clk) begin
        if (dev_out_valid && rx_n < 16) begin
            rx_data[rx_n] = dev_out_data;
            rx_last[rx_n] = dev_out_last;
            rx_n++;
        end
        if (took) src_idx++;
        dev_in_valid = src_on;
        dev_in_data  = 32'h1000 + src_idx;
        dev_in_last  = (src_idx == src_last_idx);
        took = dev_in_ready && src_on;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            rd(O_CSR, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int nlast;
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(O_CSR, v);   chk("R1 status", v, 32'h0);
        rd(O_NEXT, v);  chk("R1 next", v, 32'h0);
        rd(O_SVSP, v);  chk("R1 saved stop", v, 32'h0);
        chk("R1 irq/req/ready", {29'd0, irq, mem_req, dev_in_ready}, 32'h0);

        // R3: vector table of register writes and read-backs
        for (int i = 0; i < 8; i++) wr(VEC[i][35:32], VEC[i][31:0]);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd(VEC[i][35:32], v);
            chk("R3 readback", v, VEC[i][31:0]);
        end

        // R2: reset without init keeps addresses, with init zeroes them
        wr(O_CSR, C_RST);
        @(negedge clk);
        rd(O_NEXT, v);  chk("R2 keep next", v, 32'h0000_1234);
        rd(O_SVLIM, v); chk("R2 keep saved limit", v, 32'h1357_9BDF);
        wr(O_CSR, C_RST | C_INIT);
        @(negedge clk);
        rd(O_LIM, v);   chk("R2 init limit", v, 32'h0);
        rd(O_SVST, v);  chk("R2 init saved start", v, 32'h0);

        // R4 R6 R8 R9: single buffer memory-to-device, interrupt on
        rx_n = 0;
        wr(O_NEXT, 32'h10); wr(O_LIM, 32'h14);
        wr(O_CSR, C_SIE | C_EN);
        wait_stop();
        repeat (3) @(negedge clk);
        chk("R4 word count", rx_n, 4);
        for (int i = 0; i < 4; i++) chk("R4 word data", rx_data[i], mem_pat(32'h10 + i));
        nlast = 0;
        for (int i = 0; i < 4; i++) if (rx_last[i]) nlast++;
        chk("R10 no last without marker", nlast, 0);
        rd(O_CSR, v);   chk("R8 stopped, done, ie", v, 32'h44);
        chk("R6 irq raised", irq, 1'b1);
        rd(O_SVLIM, v); chk("R9 saved limit", v, 32'h14);
        repeat (5) @(negedge clk);
        chk("R6 irq held", irq, 1'b1);
        wr(O_CSR, C_CLR);
        @(negedge clk);
        chk("R6 irq cleared", irq, 1'b0);

        // R7 R10: chained memory-to-device, first limit carries the marker
        wr(O_CSR, C_RST);
        rx_n = 0;
        wr(O_NEXT, 32'h20); wr(O_LIM, 32'h8000_0022);
        wr(O_START, 32'h30); wr(O_STOP, 32'h33);
        wr(O_CSR, C_UPD | C_EN);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            rd(O_CSR, v);
            if (v[2]) break;
        end
        chk("R7 promoted, still enabled", v[3:0], 4'b0101);
        wait_stop();
        repeat (3) @(negedge clk);
        chk("R7 chain word count", rx_n, 5);
        chk("R7 first of second buffer", rx_data[2], mem_pat(32'h30));
        chk("R4 last data", rx_data[4], mem_pat(32'h32));
        chk("R10 last flag on buffer end", rx_last[1], 1'b1);
        nlast = 0;
        for (int i = 0; i < 5; i++) if (rx_last[i]) nlast++;
        chk("R10 single last flag", nlast, 1);
        rd(O_LIM, v);   chk("R7 limit from stop", v, 32'h33);
        rd(O_SVLIM, v); chk("R9 saved limit chain", v, 32'h33);

        // R5 R9: device-to-memory ended early by the device
        wr(O_CSR, C_RST | C_DIRW);
        src_last_idx = 2;
        @(negedge clk);
        src_idx = 0; took = 0; src_on = 1;
        wr(O_NEXT, 32'h40); wr(O_LIM, 32'h48);
        wr(O_CSR, C_EN);
        wait_stop();
        src_on = 0;
        chk("R5 word 0", bmem[8'h40], 32'h1000);
        chk("R5 word 2", bmem[8'h42], 32'h1002);
        chk("R9 nothing past last", bmem[8'h43], 32'h0);
        rd(O_SVLIM, v); chk("R9 early saved limit", v, 32'h43);

        // R11: memory error mid-buffer
        wr(O_CSR, C_RST);
        rx_n = 0;
        err_addr = 32'h52;
        wr(O_NEXT, 32'h50); wr(O_LIM, 32'h58);
        wr(O_CSR, C_EN);
        wait_stop();
        repeat (3) @(negedge clk);
        rd(O_CSR, v);   chk("R11 status", v[3:0], 4'b1100);
        rd(O_SVNXT, v); chk("R11 fault address", v, 32'h52);
        chk("R11 words before fault", rx_n, 2);
        err_addr = 32'hFFFF_FFFF;

        // R2: reset command clears bus exception and complete
        wr(O_CSR, C_RST);
        @(negedge clk);
        rd(O_CSR, v);   chk("R2 flags cleared", v[3:0], 4'b0000);

        // R12: zero-length buffer
        req_cnt = 0;
        wr(O_NEXT, 32'h60); wr(O_LIM, 32'h60);
        wr(O_CSR, C_EN);
        repeat (4) @(negedge clk);
        rd(O_CSR, v);   chk("R12 done, stopped", v[3:0], 4'b0100);
        chk("R12 no memory request", req_cnt, 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule